// File: doc/BRIEF.md
# Active Neutral-Clamped Leg Commutation Sequencer

This block controls the six gate signals of one three-level phase leg that has active switches in both neutral-clamp branches. Switches 1 and 4 are the outer devices, 2 and 3 the inner devices. Switch 5 links the neutral tap to the node between 1 and 2, and switch 6 links it to the node between 3 and 4. A modulator asks for a level (positive rail, neutral, negative rail). The sequencer moves the leg to that level through single-device gate changes, with a fixed step spacing between changes and a dead time between the last turn-off and the first turn-on.

The neutral level can be reached in four ways. When the leg leaves a rail for neutral, the block picks one of two commutation paths. The outer path stresses an outer or clamp switch. The inner path stresses an inner switch. The choice uses the phase-current sign and a hottest-switch index from a thermal estimator, so that the flagged switch does not take the switching loss. The current sign and the hottest-switch index are sampled once, when a transition is accepted. A level request that arrives while a sequence is running waits until that sequence has finished.

Top module: `anpc_leg_seq`

## Requirements
- R1: While reset is high and after it is released, all six gates are off, `busy` is low and `leg_state` is 7 (all off).
- R2: Steady states, with gate bit k-1 driving switch k and the `leg_state` code in brackets: positive [0] = 1,2,6 on; neutral-upper-outer [1] = 2,5 on; neutral-upper-inner [2] = 2,4,5 on; neutral-lower-inner [3] = 1,3,6 on; neutral-lower-outer [4] = 3,6 on; negative [5] = 3,4,5 on.
- R3: A neutral request (`lvl_req` = 00) in the positive state takes the outer path unless the flagged switch is the one that path stresses (switch 1 if `cur_pos` = 1, else switch 5). The outer path turns 6 off, then 1 off, then 5 on, and ends in state 1.
- R4: In the positive state with the flagged switch equal to the one the outer path stresses, the neutral request takes the inner path instead: 2 off, then 3 on, ending in state 3.
- R5: From the negative state the choice is mirrored. The stressed switch is 6 if `cur_pos` = 1, else 4. The outer path turns 5 off, 4 off, 6 on and ends in state 4. The inner path turns 3 off, 2 on and ends in state 2.
- R6: Every transition first turns off, one at a time, each switch on now but off in the target, in the order 5,6,1,4,2,3. It then turns on each switch off now but on in the target, in the order 2,3,1,4,5,6. A return from neutral to a rail is therefore the entering sequence reversed.
- R7: Each gate change flips exactly one bit. Consecutive turn-offs, and consecutive turn-ons, are STEP_CYC cycles apart. The first turn-on follows the last turn-off by DEAD_CYC cycles.
- R8: A level request that changes while `busy` is high waits. It starts on the cycle after the running sequence ends, with the current sign and the flagged switch sampled at that time.
- R9: Request code 11 is ignored. A neutral request while the leg is already in any neutral state starts nothing.
- R10: The gates never show 1 and 5 together, 4 and 6 together, or 2 and 3 together.
- R11: `busy` rises on the edge that accepts a request and falls on the edge of the last gate change. `leg_state` takes the new code on that same edge. Gates change only while a sequence runs. The first change comes one edge after acceptance, or DEAD_CYC+1 edges after it when nothing has to turn off.
- R12: From the all-off state, a positive request turns on 2, 1, 6 in that order, and a neutral request targets state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_req | input | 2 | Requested level: 01 positive, 00 neutral, 10 negative, 11 no request |
| cur_pos | input | 1 | Phase-current sign, 1 = positive |
| hot_sw | input | 3 | Number (1..6) of the switch flagged hottest, 0 = none |
| gate | output | 6 | Gate commands, bit k-1 drives switch k |
| leg_state | output | 3 | Code of the settled leg state |
| busy | output | 1 | A commutation sequence is running |

## Verification
The leg is walked through every steady state. It enters neutral from the positive rail with the flagged switch set to the outer-path device, set to an unrelated device, and with the current sign reversed, so a design that ignores the sign or the flag picks the wrong zero state. The negative-rail entries repeat this with mirrored indices. Direct rail-to-rail moves and returns from every neutral variant check the fixed turn-off and turn-on orders and the step and dead-time spacing of each recorded gate edge. A request changed in the middle of a sequence, ignored codes and repeated neutral requests show whether pending work is held or dropped.

// File: rtl/anpc_pkg.sv
package anpc_pkg;

  localparam int NSW = 6;
  localparam int IW  = 3;

  typedef enum logic [2:0] {
    ST_POS = 3'd0,
    ST_ZU2 = 3'd1,
    ST_ZU1 = 3'd2,
    ST_ZL1 = 3'd3,
    ST_ZL2 = 3'd4,
    ST_NEG = 3'd5,
    ST_OFF = 3'd7
  } leg_st_e;

  typedef enum logic [1:0] {
    LV_ZERO = 2'b00,
    LV_POS  = 2'b01,
    LV_NEG  = 2'b10,
    LV_NONE = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_OFFS,
    PH_ONS
  } ph_e;

  // entry i sits at [IW*i +: IW]; entry 0 is served first
  localparam logic [NSW*IW-1:0] OFF_ORDER = {3'd3, 3'd2, 3'd4, 3'd1, 3'd6, 3'd5};
  localparam logic [NSW*IW-1:0] ON_ORDER  = {3'd6, 3'd5, 3'd4, 3'd1, 3'd3, 3'd2};

  function automatic logic [NSW-1:0] st_gates(leg_st_e s);
    case (s)
      ST_POS:  st_gates = 6'b100011;
      ST_ZU2:  st_gates = 6'b010010;
      ST_ZU1:  st_gates = 6'b011010;
      ST_ZL1:  st_gates = 6'b100101;
      ST_ZL2:  st_gates = 6'b100100;
      ST_NEG:  st_gates = 6'b011100;
      default: st_gates = 6'b000000;
    endcase
  endfunction

  function automatic logic is_zero(leg_st_e s);
    is_zero = (s == ST_ZU2) || (s == ST_ZU1) || (s == ST_ZL1) || (s == ST_ZL2);
  endfunction

endpackage

// File: rtl/anpc_pick.sv
module anpc_pick #(
  parameter int N  = 6,
  parameter int IW = 3,
  parameter logic [N*IW-1:0] ORDER = '0
) (
  input  logic [N-1:0] pend,
  output logic [N-1:0] pick,
  output logic         more
);

  always_comb begin
    pick = '0;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = int'(ORDER[i*IW +: IW]) - 1;
      if ((pick == '0) && (idx >= 0) && (idx < N)) begin
        if (pend[idx]) pick[idx] = 1'b1;
      end
    end
  end

  assign more = |(pend & ~pick);

endmodule

// File: rtl/anpc_zero_sel.sv
module anpc_zero_sel
  import anpc_pkg::*;
(
  input  leg_st_e    cur_st,
  input  logic       cur_pos,
  input  logic [2:0] hot_sw,
  output leg_st_e    zero_st
);

  logic [2:0] stressed;

  always_comb begin
    stressed = 3'd0;
    zero_st  = cur_st;
    case (cur_st)
      ST_POS: begin
        stressed = cur_pos ? 3'd1 : 3'd5;
        zero_st  = (hot_sw == stressed) ? ST_ZL1 : ST_ZU2;
      end
      ST_NEG: begin
        stressed = cur_pos ? 3'd6 : 3'd4;
        zero_st  = (hot_sw == stressed) ? ST_ZU1 : ST_ZL2;
      end
      ST_OFF:  zero_st = ST_ZU2;
      default: zero_st = cur_st;
    endcase
  end

endmodule

// File: rtl/anpc_step_seq.sv
module anpc_step_seq
  import anpc_pkg::*;
#(
  parameter int STEP_CYC = 4,
  parameter int DEAD_CYC = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [NSW-1:0] tgt,
  output logic [NSW-1:0] gate_q,
  output logic           busy,
  output logic           finish
);

  localparam int TMAX = (STEP_CYC > DEAD_CYC) ? STEP_CYC : DEAD_CYC;
  localparam int TW   = (TMAX < 2) ? 1 : $clog2(TMAX + 1);
  localparam logic [TW-1:0] STEP_T = TW'(STEP_CYC - 1);
  localparam logic [TW-1:0] DEAD_T = TW'(DEAD_CYC - 1);

  ph_e            ph;
  logic [TW-1:0]  tmr;
  logic [NSW-1:0] tgt_q;
  logic [NSW-1:0] off_pend, on_pend, off_pick, on_pick;
  logic           off_more, on_more;

  assign off_pend = gate_q & ~tgt_q;
  assign on_pend  = tgt_q & ~gate_q;

  anpc_pick #(.N(NSW), .IW(IW), .ORDER(OFF_ORDER)) u_off_pick (
    .pend (off_pend),
    .pick (off_pick),
    .more (off_more)
  );

  anpc_pick #(.N(NSW), .IW(IW), .ORDER(ON_ORDER)) u_on_pick (
    .pend (on_pend),
    .pick (on_pick),
    .more (on_more)
  );

  assign busy   = (ph != PH_IDLE);
  assign finish = (ph == PH_ONS) && (tmr == '0) && !on_more;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      tmr    <= '0;
      tgt_q  <= '0;
      gate_q <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (start) begin
            tgt_q <= tgt;
            ph    <= PH_OFFS;
            tmr   <= '0;
          end
        end
        PH_OFFS: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            gate_q <= gate_q & ~off_pick;
            if (off_more) begin
              tmr <= STEP_T;
            end else begin
              ph  <= PH_ONS;
              tmr <= DEAD_T;
            end
          end
        end
        PH_ONS: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            gate_q <= gate_q | on_pick;
            if (on_more) tmr <= STEP_T;
            else         ph  <= PH_IDLE;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/anpc_leg_seq.sv
module anpc_leg_seq
  import anpc_pkg::*;
#(
  parameter int STEP_CYC = 4,
  parameter int DEAD_CYC = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] lvl_req,
  input  logic       cur_pos,
  input  logic [2:0] hot_sw,
  output logic [5:0] gate,
  output logic [2:0] leg_state,
  output logic       busy
);

  leg_st_e cur_st, tgt_st, req_st, zero_st;
  logic    start, finish;

  anpc_zero_sel u_zsel (
    .cur_st  (cur_st),
    .cur_pos (cur_pos),
    .hot_sw  (hot_sw),
    .zero_st (zero_st)
  );

  always_comb begin
    case (lvl_e'(lvl_req))
      LV_POS:  req_st = ST_POS;
      LV_NEG:  req_st = ST_NEG;
      LV_ZERO: req_st = is_zero(cur_st) ? cur_st : zero_st;
      default: req_st = cur_st;
    endcase
  end

  assign start = !busy && (req_st != cur_st);

  anpc_step_seq #(.STEP_CYC(STEP_CYC), .DEAD_CYC(DEAD_CYC)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .tgt    (st_gates(req_st)),
    .gate_q (gate),
    .busy   (busy),
    .finish (finish)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_st <= ST_OFF;
      tgt_st <= ST_OFF;
    end else begin
      if (start)  tgt_st <= req_st;
      if (finish) cur_st <= tgt_st;
    end
  end

  assign leg_state = cur_st;

endmodule

// File: rtl/anpc_leg_chk.sv
module anpc_leg_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] lvl_req,
  input logic [5:0] gate,
  input logic [2:0] leg_state,
  input logic       busy
);

  AST_NO_UPPER_SHORT: assert property (@(posedge clk) disable iff (rst)
    !(gate[0] && gate[4])); // R10
  AST_NO_LOWER_SHORT: assert property (@(posedge clk) disable iff (rst)
    !(gate[3] && gate[5])); // R10
  AST_NO_INNER_PAIR: assert property (@(posedge clk) disable iff (rst)
    !(gate[1] && gate[2])); // R10
  AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (gate != $past(gate)) |-> ($countones(gate ^ $past(gate)) == 1)); // R7
  AST_CHANGE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (gate != $past(gate)) |-> $past(busy)); // R11
  AST_NONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!busy && lvl_req == 2'b11) |=> !busy); // R9
  AST_ZERO_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!busy && lvl_req == 2'b00 && leg_state >= 3'd1 && leg_state <= 3'd4) |=> !busy); // R9
  AST_POS_STARTS: assert property (@(posedge clk) disable iff (rst)
    (!busy && lvl_req == 2'b01 && leg_state != 3'd0) |=> busy); // R11

endmodule

bind anpc_leg_seq anpc_leg_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .lvl_req   (lvl_req),
  .gate      (gate),
  .leg_state (leg_state),
  .busy      (busy)
);

// File: tb/tb_anpc_leg_seq.sv
module tb_anpc_leg_seq;

  localparam int STEP = 4;
  localparam int DEAD = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] lvl_req = 2'b11;
  logic       cur_pos = 1'b1;
  logic [2:0] hot_sw = 3'd0;
  logic [5:0] gate;
  logic [2:0] leg_state;
  logic       busy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int lg_sw [0:15];
  int lg_val[0:15];
  int lg_cyc[0:15];
  int n_log = 0;
  int multi_hits = 0;
  int short_hits = 0;
  logic [5:0] prev_g = '0;

  anpc_leg_seq #(.STEP_CYC(STEP), .DEAD_CYC(DEAD)) dut (
    .clk       (clk),
    .rst       (rst),
    .lvl_req   (lvl_req),
    .cur_pos   (cur_pos),
    .hot_sw    (hot_sw),
    .gate      (gate),
    .leg_state (leg_state),
    .busy      (busy)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst) begin
      prev_g = gate;
    end else begin
      if (gate !== prev_g) begin
        if ($countones(gate ^ prev_g) != 1) multi_hits++;
        for (int k = 0; k < 6; k++) begin
          if (gate[k] !== prev_g[k] && n_log < 16) begin
            lg_sw[n_log]  = k + 1;
            lg_val[n_log] = int'(gate[k]);
            lg_cyc[n_log] = cyc;
            n_log++;
          end
        end
      end
      if ((gate[0] & gate[4]) | (gate[3] & gate[5]) | (gate[1] & gate[2])) short_hits++;
      prev_g = gate;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 50000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_gate(input int code);
    case (code)
      0:       return 6'b100011;
      1:       return 6'b010010;
      2:       return 6'b011010;
      3:       return 6'b100101;
      4:       return 6'b100100;
      5:       return 6'b011100;
      default: return 6'b000000;
    endcase
  endfunction

  task automatic wait_idle();
    for (int t = 0; t < 2000 && busy; t++) @(negedge clk);
  endtask

  // ex holds up to nine 4-bit entries {value, switch}, first entry leftmost
  task automatic cmp_log(input int n, input logic [35:0] ex, input int base,
                         input string tag);
    chk(n_log == n, "R7", {tag, " number of gate changes"}, n_log, n);
    for (int i = 0; i < n && i < n_log; i++) begin
      logic [3:0] e;
      e = ex[35-4*i -: 4];
      chk(lg_sw[i] == int'(e[2:0]), tag, "switch of change", lg_sw[i], int'(e[2:0]));
      chk(lg_val[i] == int'(e[3]), tag, "direction of change", lg_val[i], int'(e[3]));
      if (i == 0) begin
        chk(lg_cyc[0] == base + 2 + (e[3] ? DEAD : 0), "R11", "first change cycle",
            lg_cyc[0], base + 2 + (e[3] ? DEAD : 0));
      end else begin
        int gap;
        if (lg_val[i-1] == lg_val[i]) gap = STEP;
        else if (lg_val[i-1] == 0)    gap = DEAD;
        else                          gap = 2;
        chk(lg_cyc[i] - lg_cyc[i-1] == gap, "R7", "spacing of change",
            lg_cyc[i] - lg_cyc[i-1], gap);
      end
    end
  endtask

  task automatic run_seq(input logic [1:0] lv, input logic cp, input logic [2:0] hs,
                         input int n, input logic [35:0] ex, input int fin,
                         input string tag);
    int base;
    @(negedge clk);
    n_log = 0;
    base = cyc;
    lvl_req = lv; cur_pos = cp; hot_sw = hs;
    @(negedge clk);
    chk(busy == 1'b1, "R11", "busy after accept", int'(busy), 1);
    wait_idle();
    repeat (3) @(negedge clk);
    cmp_log(n, ex, base, tag);
    chk(int'(leg_state) == fin, "R2", {tag, " settled state code"}, int'(leg_state), fin);
    chk(gate == exp_gate(fin), "R2", {tag, " settled gates"}, int'(gate), int'(exp_gate(fin)));
  endtask

  task automatic run_ignored(input logic [1:0] lv, input string what);
    int st;
    @(negedge clk);
    n_log = 0;
    st = int'(leg_state);
    lvl_req = lv;
    repeat (20) @(negedge clk);
    chk(n_log == 0, "R9", {what, " gate changes"}, n_log, 0);
    chk(busy == 1'b0, "R9", {what, " busy"}, int'(busy), 0);
    chk(int'(leg_state) == st, "R9", {what, " state"}, int'(leg_state), st);
  endtask

  task automatic run_hold();
    int base;
    @(negedge clk);
    n_log = 0;
    base = cyc;
    lvl_req = 2'b10; cur_pos = 1'b0; hot_sw = 3'd0;
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R8", "sequence running at new request", int'(busy), 1);
    lvl_req = 2'b00; cur_pos = 1'b1; hot_sw = 3'd0;
    for (int t = 0; t < 2000 && n_log < 9; t++) @(negedge clk);
    wait_idle();
    repeat (3) @(negedge clk);
    cmp_log(9, 36'h612BCD54E, base, "R8");
    chk(int'(leg_state) == 4, "R8", "state after held request", int'(leg_state), 4);
    chk(gate == exp_gate(4), "R8", "gates after held request", int'(gate), int'(exp_gate(4)));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(gate == 6'b0, "R1", "gates in reset", int'(gate), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(gate == 6'b0, "R1", "gates after reset", int'(gate), 0);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(leg_state == 3'd7, "R1", "state after reset", int'(leg_state), 7);

    run_seq(2'b01, 1'b1, 3'd0, 3, 36'hA9E000000, 0, "R12");
    run_seq(2'b00, 1'b1, 3'd0, 3, 36'h61D000000, 1, "R3");
    run_seq(2'b01, 1'b1, 3'd0, 3, 36'h59E000000, 0, "R6");
    run_seq(2'b00, 1'b0, 3'd1, 3, 36'h61D000000, 1, "R3");
    run_seq(2'b01, 1'b1, 3'd0, 3, 36'h59E000000, 0, "R6");
    run_seq(2'b00, 1'b1, 3'd1, 2, 36'h2B0000000, 3, "R4");
    run_seq(2'b10, 1'b1, 3'd0, 4, 36'h61CD00000, 5, "R6");
    run_seq(2'b00, 1'b0, 3'd4, 2, 36'h3A0000000, 2, "R5");
    run_ignored(2'b00, "neutral request in neutral");
    run_ignored(2'b11, "code 11");
    run_seq(2'b10, 1'b1, 3'd0, 2, 36'h2B0000000, 5, "R6");
    run_seq(2'b00, 1'b0, 3'd6, 3, 36'h54E000000, 4, "R5");
    run_seq(2'b01, 1'b1, 3'd0, 3, 36'h3A9000000, 0, "R6");
    run_hold();
    run_seq(2'b10, 1'b1, 3'd0, 3, 36'h6CD000000, 5, "R6");
    run_seq(2'b00, 1'b1, 3'd6, 2, 36'h3A0000000, 2, "R5");

    chk(short_hits == 0, "R10", "forbidden gate pairs seen", short_hits, 0);
    chk(multi_hits == 0, "R7", "multi-bit gate changes seen", multi_hits, 0);
    summary();
    $finish;
  end

endmodule